// File: doc/BRIEF.md
# Page History Bit Tracker

This block tracks the referenced and changed history bits of a small, fully associative data translation buffer. Each lookup names a virtual page and an access kind: load, store, touch, or touch-for-store. The block searches the entries and reports one of three outcomes one cycle after the lookup is accepted. The access can proceed, it can miss, or it can trap so that the changed bit gets recorded. A store that hits a page whose changed bit is still clear does not complete. Instead it starts an update sequence.

The update sequence works on physical addresses only. It does a single-beat read of the page table entry byte that holds the history bits. It then writes that byte back with both history bits set and every other bit unchanged. After the write completes, the block sets the changed bit in the buffer entry, so a retried store proceeds.

Entries are installed by a refill port. A refilled entry always carries the referenced bit. Its changed bit comes from the refill data. Loads and touches never set the changed bit, in the buffer or in memory.

Top module: `pgh_tracker`

## Requirements
- R1: After reset no entry is valid, `busy` and `bus_req` are low, `lk_ready` and `rf_ready` are high, and every lookup misses.
- R2: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Exactly one cycle later `rsp_valid` pulses with exactly one of `rsp_hit`, `rsp_miss`, `rsp_exc` high. A load (`lk_op`=0) that hits proceeds with `rsp_hit` and the entry's page number on `rsp_ppn`, whatever the changed bit is.
- R3: A store (`lk_op`=1) that hits an entry whose changed bit is set proceeds with `rsp_hit` and starts no bus activity.
- R4: A store that hits an entry whose changed bit is clear responds with `rsp_exc` instead of `rsp_hit`, and `busy` is high in the same cycle as the response.
- R5: Touch (`lk_op`=2) and touch-for-store (`lk_op`=3) hits always proceed with `rsp_hit`. They cause no bus activity and never set the changed bit, so a later store to the same page still traps.
- R6: A lookup that matches no valid entry responds with `rsp_miss`. It causes no bus activity and changes no entry.
- R7: A refill accepted while `rf_valid` and `rf_ready` are high overwrites entry `rf_idx` with the new page, the referenced bit set and the changed bit equal to `rf_chg`. Every valid entry carries the referenced bit.
- R8: The update sequence does exactly one read (`bus_we`=0) at the entry's physical byte address. It then does one write (`bus_we`=1) to the same address whose data is the byte read back with bit 7 (referenced) and bit 6 (changed) set and the other bits unchanged. Each bus transfer ends on a cycle with `bus_ack` high.
- R9: While `busy` is high, `lk_ready` and `rf_ready` are low and no lookup response is produced.
- R10: When the sequence finishes, `busy` falls and the trapped entry's changed bit is set, so the same store then proceeds with `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_op | input | 2 | Access kind: 0 load, 1 store, 2 touch, 3 touch-for-store |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Access proceeds |
| rsp_miss | output | 1 | No entry matches |
| rsp_exc | output | 1 | Store trapped for the changed-bit update |
| rsp_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| rf_valid | input | 1 | Refill request |
| rf_idx | input | IDX_W | Entry to overwrite |
| rf_vpn | input | VPN_W | Virtual page of the new entry |
| rf_ppn | input | PPN_W | Physical page of the new entry |
| rf_chg | input | 1 | Changed bit of the new entry |
| rf_pa | input | PA_W | Physical address of the entry's history byte |
| rf_ready | output | 1 | Refill can be accepted this cycle |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 for a byte write, 0 for a single-beat read |
| bus_addr | output | PA_W | Physical byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | Update sequence in progress |

## Verification
A changed bit stored in the wrong entry, or set too early, shows on the very next store lookup to that page. That store proceeds where it should trap, or traps where it should proceed. A changed bit set by a touch shows the same way. Every combination of entry and access kind is swept before and after each page's update, so such a fault appears in the response one cycle after the lookup is accepted. A sequencer that skips the read, writes the wrong byte or address, or releases `busy` early shows on the bus transfers and in the written memory byte within the few cycles of one sequence.

// File: rtl/pgh_pkg.sv
package pgh_pkg;

   typedef enum logic [1:0] {
      OP_LOAD     = 2'd0,
      OP_STORE    = 2'd1,
      OP_TOUCH    = 2'd2,
      OP_TOUCH_ST = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_DONE  = 2'd3
   } seq_e;

   localparam int HB_REF_BIT = 7;
   localparam int HB_CHG_BIT = 6;
   localparam logic [7:0] HB_SET_MASK = 8'((1 << HB_REF_BIT) | (1 << HB_CHG_BIT));

endpackage

// File: rtl/pgh_tlb.sv
module pgh_tlb #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PA_W    = 32,
   parameter int IDX_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [VPN_W-1:0]    wr_vpn,
   input  logic [PPN_W-1:0]    wr_ppn,
   input  logic                wr_chg,
   input  logic [PA_W-1:0]     wr_pa,
   input  logic                chg_set,
   input  logic [IDX_W-1:0]    chg_idx,
   input  logic [VPN_W-1:0]    lk_vpn,
   output logic                hit,
   output logic [IDX_W-1:0]    hit_idx,
   output logic [PPN_W-1:0]    hit_ppn,
   output logic                hit_chg,
   output logic [PA_W-1:0]     hit_pa,
   output logic [ENTRIES-1:0]  vld_vec,
   output logic [ENTRIES-1:0]  ref_vec
);

   logic               vld_q [ENTRIES];
   logic               ref_q [ENTRIES];
   logic               chg_q [ENTRIES];
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];
   logic [PA_W-1:0]    pa_q  [ENTRIES];
   logic [ENTRIES-1:0] match;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            ref_q[i] <= 1'b0;
            chg_q[i] <= 1'b0;
            vpn_q[i] <= '0;
            ppn_q[i] <= '0;
            pa_q[i]  <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            vld_q[i] <= 1'b1;
            ref_q[i] <= 1'b1;
            chg_q[i] <= wr_chg;
            vpn_q[i] <= wr_vpn;
            ppn_q[i] <= wr_ppn;
            pa_q[i]  <= wr_pa;
         end else if (chg_set && chg_idx == IDX_W'(i)) begin
            chg_q[i] <= 1'b1;
         end
      end
      assign match[i]   = vld_q[i] && (vpn_q[i] == lk_vpn);
      assign vld_vec[i] = vld_q[i];
      assign ref_vec[i] = ref_q[i];
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (match[k]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(k);
         end
      end
   end

   assign hit_ppn = ppn_q[hit_idx];
   assign hit_chg = chg_q[hit_idx];
   assign hit_pa  = pa_q[hit_idx];

endmodule

// File: rtl/pgh_classify.sv
module pgh_classify
   import pgh_pkg::*;
(
   input  op_e  op,
   input  logic hit,
   input  logic hit_chg,
   output logic go,
   output logic miss,
   output logic trap
);

   assign trap = hit && (op == OP_STORE) && !hit_chg;
   assign go   = hit && !trap;
   assign miss = !hit;

endmodule

// File: rtl/pgh_seq.sv
module pgh_seq
   import pgh_pkg::*;
#(
   parameter int PA_W  = 32,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PA_W-1:0]  start_pa,
   input  logic [IDX_W-1:0] start_idx,
   output logic             bus_req,
   output logic             bus_we,
   output logic [PA_W-1:0]  bus_addr,
   output logic [7:0]       bus_wdata,
   input  logic             bus_ack,
   input  logic [7:0]       bus_rdata,
   output logic             busy,
   output logic             chg_set,
   output logic [IDX_W-1:0] chg_idx
);

   seq_e             st_q;
   logic [PA_W-1:0]  pa_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         pa_q   <= '0;
         idx_q  <= '0;
         byte_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (start) begin
               st_q  <= SQ_READ;
               pa_q  <= start_pa;
               idx_q <= start_idx;
            end
            SQ_READ: if (bus_ack) begin
               byte_q <= bus_rdata | HB_SET_MASK;
               st_q   <= SQ_WRITE;
            end
            SQ_WRITE: if (bus_ack) st_q <= SQ_DONE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign bus_req   = (st_q == SQ_READ) || (st_q == SQ_WRITE);
   assign bus_we    = (st_q == SQ_WRITE);
   assign bus_addr  = pa_q;
   assign bus_wdata = byte_q;
   assign busy      = (st_q != SQ_IDLE);
   assign chg_set   = (st_q == SQ_DONE);
   assign chg_idx   = idx_q;

endmodule

// File: rtl/pgh_tracker.sv
module pgh_tracker
   import pgh_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PA_W    = 32,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [1:0]       lk_op,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_ready,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_exc,
   output logic [PPN_W-1:0] rsp_ppn,
   input  logic             rf_valid,
   input  logic [IDX_W-1:0] rf_idx,
   input  logic [VPN_W-1:0] rf_vpn,
   input  logic [PPN_W-1:0] rf_ppn,
   input  logic             rf_chg,
   input  logic [PA_W-1:0]  rf_pa,
   output logic             rf_ready,
   output logic             bus_req,
   output logic             bus_we,
   output logic [PA_W-1:0]  bus_addr,
   output logic [7:0]       bus_wdata,
   input  logic             bus_ack,
   input  logic [7:0]       bus_rdata,
   output logic             busy
);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("pgh_tracker: ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || PA_W < 1) begin : g_bad_width
      $error("pgh_tracker: widths must be positive");
   end

   logic               tlb_hit;
   logic [IDX_W-1:0]   tlb_idx;
   logic [PPN_W-1:0]   tlb_ppn;
   logic               tlb_chg;
   logic [PA_W-1:0]    tlb_pa;
   logic [ENTRIES-1:0] tlb_vld;
   logic [ENTRIES-1:0] tlb_ref;
   logic               cl_go, cl_miss, cl_trap;
   logic               seq_chg_set;
   logic [IDX_W-1:0]   seq_chg_idx;
   logic               accept, rf_we;

   assign lk_ready = !busy && !rf_valid;
   assign rf_ready = !busy;
   assign accept   = lk_valid && lk_ready;
   assign rf_we    = rf_valid && rf_ready;

   pgh_tlb #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .IDX_W(IDX_W)
   ) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rf_we), .wr_idx(rf_idx), .wr_vpn(rf_vpn), .wr_ppn(rf_ppn),
      .wr_chg(rf_chg), .wr_pa(rf_pa),
      .chg_set(seq_chg_set), .chg_idx(seq_chg_idx),
      .lk_vpn(lk_vpn),
      .hit(tlb_hit), .hit_idx(tlb_idx), .hit_ppn(tlb_ppn), .hit_chg(tlb_chg),
      .hit_pa(tlb_pa), .vld_vec(tlb_vld), .ref_vec(tlb_ref)
   );

   pgh_classify u_cls (
      .op(op_e'(lk_op)), .hit(tlb_hit), .hit_chg(tlb_chg),
      .go(cl_go), .miss(cl_miss), .trap(cl_trap)
   );

   pgh_seq #(.PA_W(PA_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(accept && cl_trap), .start_pa(tlb_pa), .start_idx(tlb_idx),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .busy(busy), .chg_set(seq_chg_set), .chg_idx(seq_chg_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_exc   <= 1'b0;
         rsp_ppn   <= '0;
      end else begin
         rsp_valid <= accept;
         rsp_hit   <= accept && cl_go;
         rsp_miss  <= accept && cl_miss;
         rsp_exc   <= accept && cl_trap;
         rsp_ppn   <= (accept && cl_go) ? tlb_ppn : '0;
      end
   end

endmodule

// File: rtl/pgh_tracker_chk.sv
module pgh_tracker_chk #(
   parameter int ENTRIES = 4,
   parameter int PA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         lk_op,
   input logic               lk_ready,
   input logic               rf_ready,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_exc,
   input logic               bus_req,
   input logic               bus_we,
   input logic [PA_W-1:0]    bus_addr,
   input logic [7:0]         bus_wdata,
   input logic               bus_ack,
   input logic               busy,
   input logic [ENTRIES-1:0] tlb_vld,
   input logic [ENTRIES-1:0] tlb_ref
);

   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_exc}));

   a_r2_no_stray_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_exc));

   a_r4_exc_is_store: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_exc |-> ($past(lk_op) == 2'd1));

   a_r4_exc_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_exc |-> busy);

   a_r7_valid_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_vld & ~tlb_ref) == '0);

   a_r8_read_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !bus_we);

   a_r8_hist_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> (bus_wdata[7:6] == 2'b11));

   a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!lk_ready && !rf_ready));

   a_r9_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rsp_valid);

endmodule

bind pgh_tracker pgh_tracker_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_op(lk_op), .lk_ready(lk_ready),
   .rf_ready(rf_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
   .rsp_miss(rsp_miss), .rsp_exc(rsp_exc), .bus_req(bus_req),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_ack(bus_ack), .busy(busy), .tlb_vld(tlb_vld), .tlb_ref(tlb_ref)
);

// File: tb/pgh_tracker_bench.sv
`timescale 1ns/1ps
module pgh_tracker_bench;

   localparam int N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lk_valid = 1'b0;
   logic [1:0] lk_op = 2'd0;
   logic [7:0] lk_vpn = 8'd0;
   logic       lk_ready, rsp_valid, rsp_hit, rsp_miss, rsp_exc;
   logic [7:0] rsp_ppn;
   logic       rf_valid = 1'b0;
   logic [1:0] rf_idx = 2'd0;
   logic [7:0] rf_vpn = 8'd0, rf_ppn = 8'd0, rf_pa = 8'd0;
   logic       rf_chg = 1'b0;
   logic       rf_ready, bus_req, bus_we, busy;
   logic [7:0] bus_addr, bus_wdata;
   logic       bus_ack = 1'b0;
   logic [7:0] bus_rdata = 8'd0;

   int checks = 0, failures = 0;
   bit finished = 1'b0;
   int nrd = 0, nwr = 0;
   logic [7:0] last_ra, last_wa, last_wd;
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic [7:0] e_vpn [N];
   logic [7:0] e_ppn [N];
   logic [7:0] e_pa [N];
   bit         e_chg [N];

   always #10 clk = ~clk;

   pgh_tracker #(.ENTRIES(N), .VPN_W(8), .PPN_W(8), .PA_W(8)) u_pgh_tracker (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_op(lk_op), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_exc(rsp_exc), .rsp_ppn(rsp_ppn),
      .rf_valid(rf_valid), .rf_idx(rf_idx), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
      .rf_chg(rf_chg), .rf_pa(rf_pa), .rf_ready(rf_ready),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus slave: one-cycle ack after each request
   initial begin
      for (int a = 0; a < 256; a++) begin
         mem[a]     = 8'(a * 7 + 3);
         exp_mem[a] = 8'(a * 7 + 3);
      end
      forever begin
         @(negedge clk);
         if (bus_ack) bus_ack = 1'b0;
         else if (bus_req) begin
            if (bus_we) begin
               mem[bus_addr] = bus_wdata;
               nwr++;
               last_wa = bus_addr;
               last_wd = bus_wdata;
            end else begin
               bus_rdata = mem[bus_addr];
               nrd++;
               last_ra = bus_addr;
            end
            bus_ack = 1'b1;
         end
      end
   end

   task automatic lookup(input logic [1:0] op, input logic [7:0] vpn);
      @(negedge clk);
      while (busy) @(negedge clk);
      lk_valid = 1'b1;
      lk_op    = op;
      lk_vpn   = vpn;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic refill(input int idx, input logic [7:0] vpn, input logic [7:0] ppn,
                         input bit c, input logic [7:0] pa);
      @(negedge clk);
      while (!rf_ready) @(negedge clk);
      rf_valid = 1'b1;
      rf_idx   = 2'(idx);
      rf_vpn   = vpn;
      rf_ppn   = ppn;
      rf_chg   = c;
      rf_pa    = pa;
      @(negedge clk);
      rf_valid = 1'b0;
      e_vpn[idx] = vpn;
      e_ppn[idx] = ppn;
      e_chg[idx] = c;
      e_pa[idx]  = pa;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 60) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic expect_miss(input logic [1:0] op, input logic [7:0] vpn, input string req);
      int r0 = nrd, w0 = nwr;
      lookup(op, vpn);
      chk(rsp_valid && rsp_miss && !rsp_hit && !rsp_exc, req, {rsp_valid, rsp_hit, rsp_miss, rsp_exc}, 4'b1010);
      @(negedge clk);
      chk(nrd == r0 && nwr == w0 && !busy, req, nrd + nwr, r0 + w0);
   endtask

   // one access to entry idx; expected outcome computed from the bench model
   task automatic run_op(input int idx, input logic [1:0] op);
      int r0 = nrd, w0 = nwr;
      bit trap = (op == 2'd1) && !e_chg[idx];
      string req;
      case (op)
         2'd0: req = "R2";
         2'd1: req = trap ? "R4" : "R3";
         default: req = "R5";
      endcase
      lookup(op, e_vpn[idx]);
      chk(rsp_valid && rsp_hit == !trap && rsp_exc == trap && !rsp_miss, req,
          {rsp_valid, rsp_hit, rsp_miss, rsp_exc}, {1'b1, !trap, 1'b0, trap});
      if (!trap) begin
         chk(rsp_ppn == e_ppn[idx], req, rsp_ppn, e_ppn[idx]);
         @(negedge clk);
         chk(nrd == r0 && nwr == w0 && !busy, req, nrd + nwr, r0 + w0);
      end else begin
         chk(busy && !lk_ready && !rf_ready, "R4", {busy, lk_ready, rf_ready}, 3'b100);
         lk_valid = 1'b1;
         lk_op    = 2'd0;
         lk_vpn   = e_vpn[idx];
         @(negedge clk);
         chk(!rsp_valid && busy && !lk_ready, "R9", {rsp_valid, busy, lk_ready}, 3'b010);
         lk_valid = 1'b0;
         wait_idle();
         chk(!busy, "R10", busy, 0);
         chk(nrd == r0 + 1 && nwr == w0 + 1, "R8", (nrd - r0) * 16 + (nwr - w0), 8'h11);
         chk(last_ra == e_pa[idx] && last_wa == e_pa[idx], "R8", {last_ra, last_wa}, {e_pa[idx], e_pa[idx]});
         chk(last_wd == (exp_mem[e_pa[idx]] | 8'hC0), "R8", last_wd, exp_mem[e_pa[idx]] | 8'hC0);
         exp_mem[e_pa[idx]] = exp_mem[e_pa[idx]] | 8'hC0;
         e_chg[idx] = 1'b1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !bus_req && lk_ready && rf_ready && !rsp_valid, "R1",
          {busy, bus_req, lk_ready, rf_ready, rsp_valid}, 5'b00110);
      for (int v = 0; v < 4; v++) expect_miss(2'(v), 8'h10 + 8'(v), "R1");

      // R7: fill every entry, changed bit alternating
      for (int i = 0; i < N; i++)
         refill(i, 8'h10 + 8'(i), 8'hA0 + 8'(i), i[0], 8'h40 + 8'(i * 4));

      // sweep: touches precede the store so a touch-set changed bit shows as a missing trap
      for (int pass = 0; pass < 2; pass++)
         for (int i = 0; i < N; i++) begin
            run_op(i, 2'd0);
            run_op(i, 2'd2);
            run_op(i, 2'd3);
            run_op(i, 2'd1);
         end
      // R10: after the update every store proceeds
      for (int i = 0; i < N; i++) begin
         lookup(2'd1, e_vpn[i]);
         chk(rsp_hit && !rsp_exc, "R10", {rsp_hit, rsp_exc}, 2'b10);
      end

      // R6: unmapped pages, every access kind
      for (int v = 0; v < 4; v++) expect_miss(2'(v), 8'h77, "R6");

      // R7: overwrite entry 2 with a clean page, then entry 1 with a dirty one
      refill(2, 8'h55, 8'hC7, 1'b0, 8'h90);
      expect_miss(2'd0, 8'h12, "R7");
      lookup(2'd0, 8'h55);
      chk(rsp_hit && rsp_ppn == 8'hC7, "R7", rsp_ppn, 8'hC7);
      run_op(2, 2'd3);
      run_op(2, 2'd1);
      refill(1, 8'h66, 8'hD1, 1'b1, 8'h94);
      lookup(2'd1, 8'h66);
      chk(rsp_hit && !rsp_exc && rsp_ppn == 8'hD1, "R7", {rsp_hit, rsp_exc}, 2'b10);
      run_op(1, 2'd1);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule